// File: doc/BRIEF.md
# Debounced Input Change-of-State Detector

This block watches a bank of digital input lines and records chosen level transitions, so software does not have to poll them. The inputs are synchronised to the system clock and then sampled on ticks from a power-of-two clock divider. A two-sample debounce filter turns the samples into a clean level per input. Each input has a mask bit and a polarity bit. A transition of the debounced level that is unmasked and matches the polarity sets a sticky status bit. An interrupt request is raised while any status bit is set.

Software reaches five word registers through a simple port: an address, a write strobe, write data and combinational read data. The registers are control, sample rate, mask, polarity and status. At reset the mask register has every bit set, so nothing is reported until software unmasks inputs and then sets the control bits. The usual order is to set rate, mask and polarity first, and then write control with sampling and detection on.

Top module: `cos_detector`

## Requirements
- R1: The 3-bit rate register (address 1, bits 2..0) selects the sample tick period. Code 0 gives a tick every clock. A code k from 1 to 7 gives a tick every 2^(6+2k) clocks. The register resets to 0.
- R2: Reset values are: control (address 0) = 0, mask (address 2) = 0xFFFF, polarity (address 3) = 0, status (address 4) = 0. The irq output is 0 at reset.
- R3: Register bits above each field read as 0 and ignore writes. Addresses 5 to 7 read as 0.
- R4: Control bit 0 enables sampling. While it is 0, the debounced levels do not change and no status bit is set, whatever the inputs do.
- R5: A debounced level takes a new value only after two consecutive sample ticks both see that value. At the every-clock rate, a pulse lasting one clock is ignored and a pulse lasting two clocks is accepted.
- R6: A mask bit of 1 stops its input from setting its status bit. A mask bit of 0 allows it.
- R7: A polarity bit of 1 reports rising debounced transitions. A polarity bit of 0 reports falling ones.
- R8: Control bit 1 enables detection. While it is 0, no status bit is set, but the debounced levels keep following the inputs. A level that was already absorbed produces no event when detection is turned on later.
- R9: Writing to status clears each bit written as 1 and leaves bits written as 0 unchanged.
- R10: When an event and a clear write hit the same status bit in the same clock, the bit stays set.
- R11: irq is 1 exactly when some status bit is set and control bit 0 is 1.
- R12: With rate code k > 0 and the tick counter just restarted by enabling sampling, an input change is recorded at the second tick after it, not at the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 16 | Raw input lines, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that register writes come only through wr_en and that reset starts every state bit from a known value. They do not assume anything about when din changes, because the two synchroniser stages absorb any timing. The stimulus changes din and the register port only at falling clock edges and holds each level long enough for the chosen tick period. The one exception is the glitch test, where short pulses are driven on purpose to exercise the filter. A separate sequence lines up a clear write with the exact clock in which a debounced edge lands, so the event-versus-clear rule is tested at the cycle where it matters.

// File: rtl/cos_detector.sv
module cos_detector #(
  parameter int NIN      = 16,
  parameter int DW       = 32,
  parameter int AW       = 3,
  parameter int RATE_W   = 3,
  parameter int EXP_BASE = 6,
  parameter int EXP_STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NIN-1:0] din,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int CNT_W = EXP_BASE + EXP_STEP * ((1 << RATE_W) - 1);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_RATE = AW'(1);
  localparam logic [AW-1:0] A_MASK = AW'(2);
  localparam logic [AW-1:0] A_POL  = AW'(3);
  localparam logic [AW-1:0] A_STAT = AW'(4);

  logic [1:0]        ctrl_q;
  logic [RATE_W-1:0] rate_q;
  logic [NIN-1:0]    mask_q, pol_q, stat_q;
  logic [NIN-1:0]    sync1_q, sync2_q, prev_q, deb_q;
  logic [CNT_W-1:0]  cnt_q, tick_mask;
  logic [NIN-1:0]    upd, ev, clr;
  logic              samp_en, det_en, tick;
  logic              unused_wdata;

  assign samp_en = ctrl_q[0];
  assign det_en  = ctrl_q[1];
  assign unused_wdata = ^wdata;

  always_comb begin
    if (rate_q == '0) tick_mask = '0;
    else tick_mask = (CNT_W'(1) << (EXP_BASE + EXP_STEP * int'(rate_q))) - CNT_W'(1);
  end
  assign tick = samp_en && ((cnt_q & tick_mask) == tick_mask);

  assign upd = {NIN{tick}} & ~(sync2_q ^ prev_q) & (sync2_q ^ deb_q);
  assign ev  = upd & ~(pol_q ^ sync2_q) & ~mask_q & {NIN{det_en}};
  assign clr = (wr_en && addr == A_STAT) ? wdata[NIN-1:0] : '0;
  assign irq = samp_en && (|stat_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rate_q <= '0;
      mask_q <= '1;
      pol_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:  ctrl_q <= wdata[1:0];
        A_RATE:  rate_q <= wdata[RATE_W-1:0];
        A_MASK:  mask_q <= wdata[NIN-1:0];
        A_POL:   pol_q  <= wdata[NIN-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      deb_q   <= '0;
      cnt_q   <= '0;
      stat_q  <= '0;
    end else begin
      sync1_q <= din;
      sync2_q <= sync1_q;
      cnt_q   <= samp_en ? cnt_q + CNT_W'(1) : '0;
      if (tick) prev_q <= sync2_q;
      deb_q   <= deb_q ^ upd;
      stat_q  <= (stat_q & ~clr) | ev;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[1:0]        = ctrl_q;
      A_RATE:  rdata[RATE_W-1:0] = rate_q;
      A_MASK:  rdata[NIN-1:0]    = mask_q;
      A_POL:   rdata[NIN-1:0]    = pol_q;
      A_STAT:  rdata[NIN-1:0]    = stat_q;
      default: rdata = '0;
    endcase
  end

  // R6
  masked_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & $past(mask_q)) == '0));

  // R8
  detect_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> ((stat_q & ~$past(stat_q)) == '0));

  // R4
  deb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_en |=> $stable(deb_q));

  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT) |=> ((stat_q & $past(wdata[NIN-1:0]) & ~$past(ev)) == '0));

  // R10
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((stat_q & $past(ev)) == $past(ev)));

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:NIN] == '0);
endmodule

// File: tb/cos_detector_bench.sv
module cos_detector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] din = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cos_detector u_cos_detector (
    .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [31:0] v;
    cyc(2);
    // R1 R2 reset values
    rd(0, v); chk("R2 ctrl", v, 0);
    rd(1, v); chk("R1 rate", v, 0);
    rd(2, v); chk("R2 mask", v, 32'h0000_FFFF);
    rd(3, v); chk("R2 pol", v, 0);
    rd(4, v); chk("R2 stat", v, 0);
    chk("R2 irq", {31'd0, irq}, 0);
    rst_n = 1'b1;
    cyc(2);
    rd(2, v); chk("R2 mask after release", v, 32'h0000_FFFF);

    // R3 upper bits
    wr(2, 32'hFFFF_0000); rd(2, v); chk("R3 mask upper", v, 0);
    wr(1, 32'hFFFF_FFF8); rd(1, v); chk("R3 rate upper", v, 0);
    wr(0, 32'hFFFF_FFFC); rd(0, v); chk("R3 ctrl upper", v, 0);
    rd(5, v); chk("R3 addr5", v, 0);
    rd(7, v); chk("R3 addr7", v, 0);

    // R4 sampling off: no events
    wr(2, 0); wr(3, 32'hFFFF); wr(0, 2);
    din = 16'hFFFF; cyc(20);
    rd(4, v); chk("R4 disabled no event", v, 0);
    din = 16'h0000; cyc(4);
    wr(0, 3); cyc(20);
    rd(4, v); chk("R4 enable idle", v, 0);

    // R8 detection off, levels still track
    wr(0, 1); din = 16'h00FF; cyc(12);
    rd(4, v); chk("R8 detect off", v, 0);
    wr(0, 3); cyc(12);
    rd(4, v); chk("R8 no late event", v, 0);
    din = 16'h0000; cyc(12);

    // R5 glitch filter at every-clock rate
    @(negedge clk) din = 16'h0008;
    @(negedge clk) din = 16'h0000;
    cyc(12);
    rd(4, v); chk("R5 one-clock pulse ignored", v, 0);
    @(negedge clk) din = 16'h0008;
    cyc(2);
    din = 16'h0000;
    cyc(12);
    rd(4, v); chk("R5 two-clock pulse accepted", v, 32'h0008);

    // R11 irq
    chk("R11 irq set", {31'd0, irq}, 1);
    wr(0, 2); rd(4, v);
    chk("R11 irq gated", {31'd0, irq}, 0);
    chk("R11 status kept", v, 32'h0008);
    wr(0, 3);
    // R9 w1c partial
    wr(4, 32'h0000_0004); rd(4, v); chk("R9 zero bits kept", v, 32'h0008);
    wr(4, 32'h0000_0008); rd(4, v); chk("R9 cleared", v, 0);
    chk("R11 irq low", {31'd0, irq}, 0);

    // R6 R7 sweep over every input and polarity
    for (int i = 0; i < 16; i++) begin
      for (int p = 0; p < 2; p++) begin
        wr(2, 32'hFFFF); din = 16'h0000; cyc(8);
        wr(4, 32'hFFFF);
        wr(3, p ? 32'hFFFF : 32'h0);
        wr(2, {16'h0, ~(16'h1 << i)});
        din = 16'hFFFF; cyc(8);
        rd(4, v); chk("R6 R7 after rise", v, p ? (32'h1 << i) : 32'h0);
        din = 16'h0000; cyc(8);
        rd(4, v); chk("R6 R7 after fall", v, 32'h1 << i);
      end
    end

    // R10 event in the same clock as its clear
    wr(2, 32'hFFFE); wr(3, 32'h1); wr(4, 32'hFFFF);
    din = 16'h0001; cyc(8); din = 16'h0000; cyc(8);
    rd(4, v); chk("R10 preset", v, 1);
    @(negedge clk) din = 16'h0001;
    repeat (3) @(posedge clk);
    @(negedge clk) begin wr_en = 1'b1; addr = 3'd4; wdata = 32'h1; end
    @(negedge clk) wr_en = 1'b0;
    rd(4, v); chk("R10 event wins", v, 1);
    wr(4, 32'h1); rd(4, v); chk("R10 later clear", v, 0);
    din = 16'h0000; cyc(8);

    // R12 R1 divided rates
    wr(0, 0); wr(1, 1); wr(2, 0); wr(3, 32'hFFFF); wr(4, 32'hFFFF);
    wr(0, 3); din = 16'hFFFF;
    cyc(400); rd(4, v); chk("R12 rate1 first tick only", v, 0);
    cyc(200); rd(4, v); chk("R12 rate1 second tick", v, 32'hFFFF);
    wr(0, 0); wr(1, 2); wr(3, 0); wr(4, 32'hFFFF);
    wr(0, 3); din = 16'h0000;
    cyc(1500); rd(4, v); chk("R1 rate2 early", v, 0);
    cyc(800); rd(4, v); chk("R1 rate2 recorded", v, 32'hFFFF);

    done = 1'b1;
    report();
  end
endmodule